// File: doc/BRIEF.md
# Serial Receive Buffer with Idle Timeout

This block sits between a serial deserializer and the processor. Each received character arrives as a 16-bit word: the data byte plus whatever error bits the deserializer attaches. The word is pushed with a one-cycle valid strobe into a 32-deep first-in first-out store. The processor sees the oldest word at all times and removes it with a pop strobe. A ready flag tells the processor that enough words have piled up to be worth a burst read. The threshold is a programmable trigger level, commonly 1 or 8.

A few characters can arrive and then the line goes quiet, leaving the store below the threshold. An idle timer catches this case. It counts eight character times, where one character time is a programmable number of clock cycles. When it runs out, a sticky timeout flag is raised. Any push or pop starts the count again. A push into a full store is dropped, and two sticky error flags record it. The three sticky flags are cleared by writing ones. A single interrupt output combines the timeout flag and the ready flag, each under its own enable.

Top module: `uart_rx_buffer`

## Requirements
- R1: Words leave in the order they were accepted. Up to 32 words of 16 bits are held, and `level` reports the number of words held (0 to 32).
- R2: `rxReady` is 1 exactly when `level` is strictly greater than `trigLevel`.
- R3: Suppose `charCycles` is non-zero and the store is non-empty with `rxReady` low. Then `ageFlag` becomes 1 after exactly 8×`charCycles` clock edges following the edge that accepted the last push or pop. With `charCycles` = 4, it is still 0 after edge 31 and is 1 after edge 32.
- R4: An accepted push or pop restarts the idle count from zero.
- R5: The idle count does not advance while the store is empty or `rxReady` is high, so `ageFlag` is not raised in those states.
- R6: When `level` is 32, a push without a pop in the same cycle is dropped. It sets both `overrunErr` and `overflowFlag`, and it leaves `level` and the stored words unchanged.
- R7: While the store is empty, `popValid` is 0 and `popData` is 0. A pop request in that state changes nothing.
- R8: The sticky flags are cleared by writing ones to `statusClr`: bit 0 clears `ageFlag`, bit 1 clears `overrunErr`, bit 2 clears `overflowFlag`. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq` is (`ageFlag` AND `ageIrqEn`) OR (`rxReady` AND `rdyIrqEn`).
- R10: After reset, `level` is 0 and all flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Received word strobe |
| pushData | input | 16 | Received word (data plus error bits) |
| popReq | input | 1 | Remove the oldest word |
| popData | output | 16 | Oldest word, 0 when empty |
| popValid | output | 1 | Store holds at least one word |
| trigLevel | input | 6 | Ready threshold |
| charCycles | input | 16 | Clock cycles per character time, 0 turns the idle timer off |
| ageIrqEn | input | 1 | Timeout interrupt enable |
| rdyIrqEn | input | 1 | Ready interrupt enable |
| statusClr | input | 3 | Write-one-to-clear for the sticky flags |
| level | output | 6 | Words held |
| rxReady | output | 1 | Level above threshold |
| ageFlag | output | 1 | Idle timeout occurred (sticky) |
| overrunErr | output | 1 | Character lost to a full store (sticky) |
| overflowFlag | output | 1 | Store overflowed (sticky) |
| irq | output | 1 | Interrupt request |

## Verification
The bench places the timeout exactly. It checks the flag one cycle before and one cycle after the expected edge, so a timer that is off by one character or one cycle is caught. It restarts the timer partway through with a second push; a design that ignores this activity would time out early. It lets the store sit idle both empty and above the threshold, where a timer that runs anyway would raise a spurious flag. It fills the store and pushes once more, then drains it, which also wraps the pointers. A design that overwrote the oldest word or accepted the extra one would break the scoreboard order, and one that popped from an empty store would return stale data or drift the level.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobes_t;
endpackage

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = (count == '0) ? '0 : mem[rdPtr];
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int CHAR_W    = 16,
  parameter int AGE_CHARS = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AC_W  = (AGE_CHARS > 1) ? $clog2(AGE_CHARS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic              popReq,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic [CHAR_W-1:0] charCycles,
  input  logic [2:0]        statusClr,
  output fifoStrobes_t      strobes,
  output logic              rxReady,
  output logic              ageFlag,
  output logic              overrunErr,
  output logic              overflowFlag
);
  logic isEmpty, isFull, doPop, doPush, dropPush;
  logic timerEligible, running, expire, ageDone;
  logic [CHAR_W-1:0] subCnt;
  logic [AC_W-1:0]   charCnt;

  assign isEmpty  = (count == '0);
  assign isFull   = (count == CNT_W'(DEPTH));
  assign doPop    = popReq && !isEmpty;
  assign doPush   = pushValid && (!isFull || doPop);
  assign dropPush = pushValid && isFull && !doPop;
  assign strobes  = '{push: doPush, pop: doPop};
  assign rxReady  = (count > trigLevel);

  // decision taken from the ready and empty flags
  assign timerEligible = !isEmpty && !rxReady && (charCycles != '0);
  assign running = timerEligible && !ageDone;
  assign expire  = running && (subCnt == CHAR_W'(charCycles - 1'b1))
                   && (charCnt == AC_W'(AGE_CHARS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt  <= '0;
      charCnt <= '0;
      ageDone <= 1'b0;
    end else if (doPush || doPop || !timerEligible) begin
      subCnt  <= '0;
      charCnt <= '0;
      ageDone <= 1'b0;
    end else if (running) begin
      if (subCnt == CHAR_W'(charCycles - 1'b1)) begin
        subCnt <= '0;
        if (charCnt == AC_W'(AGE_CHARS - 1)) begin
          charCnt <= '0;
          ageDone <= 1'b1;
        end else begin
          charCnt <= charCnt + 1'b1;
        end
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageFlag      <= 1'b0;
      overrunErr   <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      if (expire)            ageFlag <= 1'b1;
      else if (statusClr[0]) ageFlag <= 1'b0;
      if (dropPush)          overrunErr <= 1'b1;
      else if (statusClr[1]) overrunErr <= 1'b0;
      if (dropPush)          overflowFlag <= 1'b1;
      else if (statusClr[2]) overflowFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rx_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int DATA_W    = 16,
  parameter int CHAR_W    = 16,
  parameter int AGE_CHARS = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              popValid,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic [CHAR_W-1:0] charCycles,
  input  logic              ageIrqEn,
  input  logic              rdyIrqEn,
  input  logic [2:0]        statusClr,
  output logic [CNT_W-1:0]  level,
  output logic              rxReady,
  output logic              ageFlag,
  output logic              overrunErr,
  output logic              overflowFlag,
  output logic              irq
);
  fifoStrobes_t strobes;

  uart_rx_ctrl #(.DEPTH(DEPTH), .CHAR_W(CHAR_W), .AGE_CHARS(AGE_CHARS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
    .count(level), .trigLevel(trigLevel), .charCycles(charCycles),
    .statusClr(statusClr), .strobes(strobes), .rxReady(rxReady),
    .ageFlag(ageFlag), .overrunErr(overrunErr), .overflowFlag(overflowFlag)
  );

  uart_rx_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(pushData),
    .headData(popData), .count(level)
  );

  assign popValid = (level != '0);
  assign irq = (ageFlag && ageIrqEn) || (rxReady && rdyIrqEn);
endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             pushValid,
  input logic             popReq,
  input logic [CNT_W-1:0] level,
  input logic             rxReady,
  input logic             ageFlag,
  input logic             overrunErr,
  input logic             overflowFlag,
  input logic [2:0]       statusClr
);
  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= CNT_W'(DEPTH));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !popReq && level == CNT_W'(DEPTH))
    |=> (overrunErr && overflowFlag && level == CNT_W'(DEPTH)));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushValid && level == '0) |=> (level == '0));

  // R5
  age_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ageFlag) |-> $past(level != '0 && !rxReady));

  // R8
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr[1] && !(pushValid && !popReq && level == CNT_W'(DEPTH)))
    |=> !overrunErr);
endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
  .level(level), .rxReady(rxReady), .ageFlag(ageFlag),
  .overrunErr(overrunErr), .overflowFlag(overflowFlag), .statusClr(statusClr)
);

// File: tb/uart_rx_buffer_tb.sv
module uart_rx_buffer_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        pushValid = 0;
  logic [15:0] pushData = 0;
  logic        popReq = 0;
  logic [15:0] popData;
  logic        popValid;
  logic [5:0]  trigLevel = 6'd8;
  logic [15:0] charCycles = 0;
  logic        ageIrqEn = 0, rdyIrqEn = 0;
  logic [2:0]  statusClr = 0;
  logic [5:0]  level;
  logic        rxReady, ageFlag, overrunErr, overflowFlag, irq;

  int total = 0, bad = 0;
  logic [15:0] expQ[$];

  always #10 clk = ~clk;

  uart_rx_buffer u_dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .popReq(popReq), .popData(popData), .popValid(popValid),
    .trigLevel(trigLevel), .charCycles(charCycles), .ageIrqEn(ageIrqEn),
    .rdyIrqEn(rdyIrqEn), .statusClr(statusClr), .level(level),
    .rxReady(rxReady), .ageFlag(ageFlag), .overrunErr(overrunErr),
    .overflowFlag(overflowFlag), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one accepted push per call, expected item queued if room
  task automatic push(input logic [15:0] d);
    @(posedge clk); #1;
    pushValid = 1; pushData = d;
    if (expQ.size() < 32) expQ.push_back(d);
    @(posedge clk); #1;
    pushValid = 0;
  endtask

  task automatic pop();
    @(posedge clk); #1;
    popReq = 1;
    @(posedge clk); #1;
    popReq = 0;
  endtask

  task automatic clearAll();
    @(posedge clk); #1;
    statusClr = 3'b111;
    @(posedge clk); #1;
    statusClr = 0;
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each word as it is popped
  always @(negedge clk) begin
    if (popReq) begin
      if (popValid) begin
        if (expQ.size() == 0) check("R1 unexpected word", popData, -1);
        else check("R1 order", popData, expQ.pop_front());
      end else begin
        check("R7 empty popData", popData, 0);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 level", level, 0);
    check("R10 flags", {rxReady, ageFlag, overrunErr, overflowFlag, irq}, 0);
    check("R7 popValid idle", popValid, 0);

    // R1 ordering, R2 ready threshold with trigLevel 8
    for (int i = 0; i < 3; i++) push(16'hA100 + 16'(i));
    @(negedge clk);
    check("R1 level", level, 3);
    check("R2 not ready", rxReady, 0);
    for (int i = 0; i < 3; i++) pop();
    @(negedge clk);
    check("R1 drained", level, 0);

    // R2 with trigLevel 1, R9 ready interrupt
    trigLevel = 6'd1; rdyIrqEn = 1;
    push(16'h0011);
    @(negedge clk);
    check("R2 level==trig", rxReady, 0);
    check("R9 no irq", irq, 0);
    push(16'h0022);
    @(negedge clk);
    check("R2 level>trig", rxReady, 1);
    check("R9 ready irq", irq, 1);
    rdyIrqEn = 0;
    // R5 no ageing while ready
    charCycles = 16'd4;
    waitNeg(60);
    check("R5 no age when ready", ageFlag, 0);
    pop(); pop();
    // R5 no ageing while empty
    waitNeg(60);
    check("R5 no age when empty", ageFlag, 0);

    // R3 exact timeout with trigLevel 8, charCycles 4
    trigLevel = 6'd8; ageIrqEn = 1;
    push(16'h0B0B);
    waitNeg(32);
    check("R3 before expiry", ageFlag, 0);
    waitNeg(1);
    check("R3 at expiry", ageFlag, 1);
    check("R9 age irq", irq, 1);
    // R8 write-one-to-clear
    clearAll();
    @(negedge clk);
    check("R8 age cleared", ageFlag, 0);
    check("R9 irq dropped", irq, 0);

    // R4 restart on activity
    push(16'h0C0C);
    waitNeg(20);
    push(16'h0D0D);
    waitNeg(32);
    check("R4 restarted", ageFlag, 0);
    waitNeg(1);
    check("R4 expiry after restart", ageFlag, 1);
    charCycles = 0; ageIrqEn = 0;
    pop(); pop(); pop();
    clearAll();

    // R6 overflow: fill, push extra, drain
    for (int i = 0; i < 32; i++) push(16'h5000 + 16'(i));
    @(negedge clk);
    check("R6 full level", level, 32);
    check("R6 no flag yet", overrunErr, 0);
    push(16'hDEAD);
    @(negedge clk);
    check("R6 overrun", overrunErr, 1);
    check("R6 overflow", overflowFlag, 1);
    check("R6 level kept", level, 32);
    // R8 selective clear
    @(posedge clk); #1; statusClr = 3'b010;
    @(posedge clk); #1; statusClr = 0;
    @(negedge clk);
    check("R8 overrun cleared", overrunErr, 0);
    check("R8 overflow kept", overflowFlag, 1);
    for (int i = 0; i < 32; i++) pop();
    @(negedge clk);
    check("R6 drained", level, 0);
    check("R1 queue empty", expQ.size(), 0);

    // R7 pop from empty
    pop();
    @(negedge clk);
    check("R7 level stays", level, 0);
    check("R7 popValid", popValid, 0);
    // R1 after pointer wrap
    push(16'h7777); push(16'h8888);
    pop(); pop();
    @(negedge clk);
    check("R1 wrap drained", level, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule